// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block sits beside an I2C slave controller and watches the synchronised SCL and SDA lines. It raises an SMBus timeout when the clock line is held low for too long while the slave is taking part in a transaction. The monitor finds START and STOP conditions on the bus by itself. It keeps a single engaged/idle state. A START moves it to engaged. A STOP, an address-mismatch pulse from the slave core, or disabling the controller returns it to idle.

While the monitor is engaged, SMBus mode is on, the controller is enabled and not acting as bus master, and SCL is low, a counter of system clocks runs. Any other condition holds the counter at zero. The count limit is the timeout duration in milliseconds times the clock rate in kHz. When the count reaches that limit, a sticky timeout flag is set. The flag stays set until software writes a clear strobe. An interrupt output follows the flag when its enable is on. When the controller is disabled, the block asks the bus drivers to release both lines.

Top module: `smb_scl_timeout`

## Requirements
- R1: After reset, `tmo_flag`, `tmo_irq` and `engaged` are 0. `release_req` is 0 while `ctl_en` is 1.
- R2: While the monitor is idle (no START seen, or returned to idle), the timeout never fires, however long SCL stays low.
- R3: A START (SDA falling while SCL is high) moves the monitor to engaged. Once engaged, `tmo_flag` rises on the clock edge that is LIMIT+2 cycles after `scl_i` falls, where LIMIT = CLK_KHZ*TIMEOUT_MS. The extra 2 cycles come from the two-flop synchroniser. The flag is still 0 one cycle earlier.
- R4: With `smb_en` at 0, the counter stays at zero and no timeout occurs. START/STOP tracking continues.
- R5: Any synchronised SCL-high cycle clears the count, so a new low interval is timed from zero.
- R6: `tmo_irq` is 1 exactly when `tmo_flag` is 1 and `tmo_ie` is 1.
- R7: `tmo_flag` stays set until `tmo_clr` is 1 at a clock edge, which clears it.
- R8: A one-cycle `addr_miss` pulse while engaged returns the monitor to idle, and the timer stays inactive.
- R9: A STOP (SDA rising while SCL is high) returns the monitor to idle. A repeated START while engaged keeps it engaged.
- R10: With `master_mode` at 1 or `ctl_en` at 0, the timer is held at zero and no START engages the monitor. `ctl_en` at 0 also forces idle and sets `release_req` to 1.
- R11: The flag fires at most once per SCL-low interval. After a clear during the same low interval, it does not set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| ctl_en | input | 1 | Slave controller enable |
| smb_en | input | 1 | SMBus timeout mode enable |
| master_mode | input | 1 | Controller is acting as bus master |
| addr_miss | input | 1 | Pulse from slave core: address is not ours |
| tmo_ie | input | 1 | Timeout interrupt enable |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout interrupt |
| release_req | output | 1 | Request to release SDA and SCL |
| engaged | output | 1 | Monitor has left idle after a START |

## Verification
The hardest state to reach from the ports is the clear strobe arriving while SCL is still low after a timeout. The saturated counter must then stop the flag from setting again. The bench first drives a START and holds SCL low past the limit. It pulses the clear while SCL stays low. Only after that does it release and lower SCL again, to show that a fresh interval is timed. A repeated START also needs a careful sequence: SDA is raised while SCL is low, then SCL is raised, so the SDA fall that follows is a START and not a STOP.

// File: rtl/smb_scl_timeout.sv
module smb_scl_timeout #(
  parameter int CLK_KHZ    = 200000,
  parameter int TIMEOUT_MS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic ctl_en,
  input  logic smb_en,
  input  logic master_mode,
  input  logic addr_miss,
  input  logic tmo_ie,
  input  logic tmo_clr,
  output logic tmo_flag,
  output logic tmo_irq,
  output logic release_req,
  output logic engaged
);
  localparam int LIMIT = CLK_KHZ * TIMEOUT_MS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [CW-1:0] cnt;

  wire scl_s2   = scl_sy[1];
  wire sda_s2   = sda_sy[1];
  wire start_c  = scl_s2 & scl_q & sda_q & ~sda_s2;
  wire stop_c   = scl_s2 & scl_q & ~sda_q & sda_s2;
  wire slave_on = ctl_en & ~master_mode;
  wire run      = engaged & smb_en & slave_on & ~scl_s2;
  wire hit      = run & (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s2;
      sda_q  <= sda_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  engaged <= 1'b0;
    else if (!slave_on)          engaged <= 1'b0;
    else if (start_c)            engaged <= 1'b1;
    else if (stop_c | addr_miss) engaged <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run)                cnt <= '0;
    else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (hit)     tmo_flag <= 1'b1;
    else if (tmo_clr) tmo_flag <= 1'b0;
  end

  assign tmo_irq     = tmo_flag & tmo_ie;
  assign release_req = ~ctl_en;
endmodule

module smb_scl_timeout_chk #(
  parameter int LIMIT = 2,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_en,
  input logic          smb_en,
  input logic          tmo_ie,
  input logic          tmo_clr,
  input logic          tmo_flag,
  input logic          tmo_irq,
  input logic          engaged,
  input logic          scl_s2,
  input logic [CW-1:0] cnt
);
  assert_flag_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> cnt == CW'(LIMIT));
  assert_idle_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !engaged |=> cnt == '0);
  assert_smb_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !smb_en |=> cnt == '0);
  assert_scl_high_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_s2 |=> cnt == '0);
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_ie |-> !tmo_irq);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !tmo_clr |=> tmo_flag);
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !engaged && cnt == '0);
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

bind smb_scl_timeout smb_scl_timeout_chk #(.LIMIT(LIMIT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .smb_en(smb_en),
  .tmo_ie(tmo_ie), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag), .tmo_irq(tmo_irq),
  .engaged(engaged), .scl_s2(scl_s2), .cnt(cnt)
);

// File: tb/smb_scl_timeout_tb.sv
`timescale 1ns/1ps
module smb_scl_timeout_tb;
  localparam int KHZ = 2;
  localparam int MS  = 30;
  localparam int LIM = KHZ * MS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic ctl_en = 1'b1, smb_en = 1'b1, master_mode = 1'b0;
  logic addr_miss = 1'b0, tmo_ie = 1'b0, tmo_clr = 1'b0;
  logic tmo_flag, tmo_irq, release_req, engaged;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smb_scl_timeout #(.CLK_KHZ(KHZ), .TIMEOUT_MS(MS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .ctl_en(ctl_en), .smb_en(smb_en), .master_mode(master_mode),
    .addr_miss(addr_miss), .tmo_ie(tmo_ie), .tmo_clr(tmo_clr),
    .tmo_flag(tmo_flag), .tmo_irq(tmo_irq), .release_req(release_req),
    .engaged(engaged)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_i = 1'b0; tick(4); scl_i = 1'b0;
  endtask

  task automatic bus_stop();
    sda_i = 1'b0; tick(2); scl_i = 1'b1; tick(4); sda_i = 1'b1; tick(4);
  endtask

  task automatic clear_flag();
    tmo_clr = 1'b1; tick(1); tmo_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(tmo_flag, 1'b0, "R1 flag after reset");
    check(tmo_irq, 1'b0, "R1 irq after reset");
    check(engaged, 1'b0, "R1 engaged after reset");
    check(release_req, 1'b0, "R1 release_req after reset");
  endtask

  task automatic t_idle_low();
    scl_i = 1'b0; tick(LIM * 3);
    check(tmo_flag, 1'b0, "R2 idle SCL low no timeout");
    scl_i = 1'b1; tick(4);
  endtask

  task automatic t_threshold();
    tmo_ie = 1'b1;
    bus_start();
    tick(LIM + 1);
    check(tmo_flag, 1'b0, "R3 one cycle before limit");
    check(engaged, 1'b1, "R3 engaged after START");
    tick(1);
    check(tmo_flag, 1'b1, "R3 flag at limit");
    check(tmo_irq, 1'b1, "R6 irq with enable");
    tmo_ie = 1'b0; tick(1);
    check(tmo_irq, 1'b0, "R6 irq masked");
    tick(10);
    check(tmo_flag, 1'b1, "R7 flag sticky");
    clear_flag();
    check(tmo_flag, 1'b0, "R7 cleared by strobe");
    tick(LIM + 5);
    check(tmo_flag, 1'b0, "R11 no refire same interval");
    scl_i = 1'b1; tick(3); scl_i = 1'b0;
    tick(LIM + 2);
    check(tmo_flag, 1'b1, "R3 new interval fires again");
    clear_flag();
    bus_stop();
  endtask

  task automatic t_smb_off();
    smb_en = 1'b0;
    bus_start(); tick(LIM * 2);
    check(tmo_flag, 1'b0, "R4 smb mode off no timeout");
    check(engaged, 1'b1, "R4 tracking still active");
    bus_stop();
    smb_en = 1'b1;
  endtask

  task automatic t_scl_high_reset();
    bus_start(); tick(LIM - 5);
    scl_i = 1'b1; tick(3); scl_i = 1'b0;
    tick(LIM - 5);
    check(tmo_flag, 1'b0, "R5 count restarted after SCL high");
    tick(7);
    check(tmo_flag, 1'b1, "R5 full interval after restart");
    clear_flag();
    bus_stop();
  endtask

  task automatic t_addr_miss();
    bus_start(); tick(5);
    addr_miss = 1'b1; tick(1); addr_miss = 1'b0;
    check(engaged, 1'b0, "R8 addr miss returns to idle");
    tick(LIM * 2);
    check(tmo_flag, 1'b0, "R8 no timeout after miss");
    scl_i = 1'b1; tick(4);
  endtask

  task automatic t_stop_restart();
    bus_start(); tick(5);
    sda_i = 1'b1; tick(2); scl_i = 1'b1; tick(4);
    sda_i = 1'b0; tick(4);
    check(engaged, 1'b1, "R9 repeated START stays engaged");
    sda_i = 1'b1; tick(4);
    check(engaged, 1'b0, "R9 STOP returns to idle");
    scl_i = 1'b0; tick(LIM * 2);
    check(tmo_flag, 1'b0, "R9 no timeout after STOP");
    scl_i = 1'b1; tick(4);
  endtask

  task automatic t_master_disable();
    master_mode = 1'b1;
    bus_start(); tick(LIM * 2);
    check(engaged, 1'b0, "R10 master mode blocks engage");
    check(tmo_flag, 1'b0, "R10 master mode no timeout");
    scl_i = 1'b1; tick(2); sda_i = 1'b1; tick(4);
    master_mode = 1'b0;
    bus_start(); tick(3);
    ctl_en = 1'b0; #1;
    check(release_req, 1'b1, "R10 release request when disabled");
    tick(1);
    check(engaged, 1'b0, "R10 disable forces idle");
    tick(LIM * 2);
    check(tmo_flag, 1'b0, "R10 disabled no timeout");
    ctl_en = 1'b1; #1;
    check(release_req, 1'b0, "R10 release request dropped");
    scl_i = 1'b1; tick(2); sda_i = 1'b1; tick(4);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_idle_low();
    t_threshold();
    t_smb_off();
    t_scl_high_reset();
    t_addr_miss();
    t_stop_restart();
    t_master_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule